// File: doc/BRIEF.md
# Run-Mode Clock Source Switch Controller

This block chooses which of three oscillators clocks the CPU and the peripherals: a primary crystal source (optionally multiplied by a PLL), a slow secondary oscillator, or an internal oscillator block with a selectable postscaler. Software writes a 2-bit select value. The controller powers the primary source up when it is needed and down when it is not. Before it hands over to the primary source, it waits for that source to start up and for the PLL to lock. The change itself is glitch-free, and the controller reports whether the primary source is stable.

All timing is expressed in cycles of one fast reference clock. Each oscillator is a tick-enable generator, and the system clock leaves the block as the enable stream `sys_tick`. The state machine has four states. ST_RUN is steady operation. ST_STARTUP counts primary-oscillator ticks. ST_LOCK counts reference cycles for the PLL. ST_HANDOFF holds the output quiet while it counts destination ticks.

The transitions are named as follows:
- **request** (ST_RUN to ST_STARTUP or ST_HANDOFF) is taken on a new synchronized select value.
- **started** (ST_STARTUP to ST_LOCK, or to ST_HANDOFF when the PLL is off) is taken when the start-up count is reached.
- **locked** (ST_LOCK to ST_HANDOFF) is taken when the lock interval ends.
- **swapped** (ST_HANDOFF to ST_RUN) is taken after two destination ticks.
- **retarget** (any state to ST_STARTUP, ST_HANDOFF or ST_RUN) is taken when a newer select value arrives during a pending switch.

Top module: `clksw_top`

## Requirements
- R1: The select input decodes as follows: 00 is the primary source, 01 is the secondary source, and 1x is the internal block, where the low bit is ignored. `active_src` reports the running source as 00 for primary, 01 for secondary and 10 for internal. It never shows 11. Changing the select between 10 and 11 causes no change and no gap in `sys_tick`.
- R2: After reset, `active_src` is 00, `pri_stable` is 0, `pri_on` is 1 and no `sys_tick` is produced. The first tick only comes after the start-up count and the lock interval.
- R3: A switch to the primary source powers it (`pri_on`=1) and waits OST_TICKS = 1024 primary ticks. When USE_PLL is 1, it then waits LOCK_CYC reference cycles. Only after both waits does the handoff begin.
- R4: During the start-up and lock waits, `active_src` is unchanged and `sys_tick` keeps the period of the old source.
- R5: While a handoff is in progress, `sys_tick` stays low. The first destination tick arrives within four destination periods after the last old tick. No two ticks are ever closer than the shorter of the two source periods, and never in adjacent reference cycles.
- R6: `pri_stable` is set when a handoff to the primary source completes. It is cleared when a handoff to the secondary source or the internal block completes, and at that point `pri_on` drops. `pri_stable` is 0 whenever `active_src` is not 00.
- R7: The internal period is INT_DIV * 2^`int_div_sel` reference cycles. A change to `int_div_sel` takes effect at once, with no handoff and no change of `active_src`.
- R8: Every change of source takes a handoff, including a change between the secondary source and the internal block.
- R9: A new select value that arrives during a pending switch restarts the sequence toward the newest target. If the newest target is the source already running, the switch is dropped and that source keeps running.
- R10: With default parameters, the `sys_tick` period is 2 reference cycles on the primary source, 16 on the secondary source, and 4 on the internal block when `int_div_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_in | input | 2 | Source select value |
| int_div_sel | input | PSW | Internal postscaler exponent |
| sys_tick | output | 1 | System clock enable pulse |
| active_src | output | 2 | Source currently driving `sys_tick` |
| pri_stable | output | 1 | Primary source stable and in use |
| pri_on | output | 1 | Primary oscillator power enable |

## Verification
Two events can coincide: a new select value can arrive while a handoff is completing, or while the start-up count is running. When they meet, the retarget path must win over the swapped or started path. The bench provokes this in two ways. It writes a select value a few cycles after a handoff away from the primary source has begun, and it writes a new target in the middle of a primary start-up. It then judges the result at the ports by three things: the source that ends up running, the `pri_stable` and `pri_on` levels, and the measured tick period.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

    typedef enum logic [1:0] {
        SRC_PRI = 2'b00,
        SRC_SEC = 2'b01,
        SRC_INT = 2'b10
    } src_e;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_STARTUP,
        ST_LOCK,
        ST_HANDOFF
    } st_e;

    function automatic src_e decode_sel(input logic [1:0] s);
        if (s[1])
            return SRC_INT;
        else if (s[0])
            return SRC_SEC;
        else
            return SRC_PRI;
    endfunction

endpackage

// File: rtl/clksw_divider.sv
module clksw_divider #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (!en) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= (cnt == W'(DIV - 1));
            cnt  <= (cnt == W'(DIV - 1)) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/clksw_postscale.sv
module clksw_postscale #(
    parameter int PSW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           base_tick,
    input  logic [PSW-1:0] exp_sel,
    output logic           tick
);
    localparam int PCW = (1 << PSW) - 1;

    logic [PCW-1:0] cnt;
    logic [PCW-1:0] lim;

    always_comb lim = ({{(PCW-1){1'b0}}, 1'b1} << exp_sel) - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (base_tick) begin
                if (cnt >= lim) begin
                    cnt  <= '0;
                    tick <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/clksw_fsm.sv
module clksw_fsm
    import clksw_pkg::*;
#(
    parameter int OST_TICKS = 1024,
    parameter int LOCK_CYC  = 64,
    parameter bit USE_PLL   = 1'b1,
    parameter int CW        = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  src_e       tgt,
    input  logic [2:0] src_tick,
    output src_e       cur,
    output logic       out_en,
    output logic       pri_stable,
    output logic       pri_on
);
    st_e           st_q, st_n;
    src_e          cur_q, cur_n, tgt_q, tgt_n;
    logic          en_q, en_n, stb_q, stb_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic          dest_tick, pri_tick;

    always_comb begin
        dest_tick = src_tick[tgt_q];
        pri_tick  = src_tick[SRC_PRI];
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_STARTUP;
            cur_q <= SRC_PRI;
            tgt_q <= SRC_PRI;
            en_q  <= 1'b0;
            stb_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cur_q <= cur_n;
            tgt_q <= tgt_n;
            en_q  <= en_n;
            stb_q <= stb_n;
            cnt_q <= cnt_n;
        end
    end

    // Next state
    always_comb begin
        st_n  = st_q;
        cur_n = cur_q;
        tgt_n = tgt_q;
        en_n  = en_q;
        stb_n = stb_q;
        cnt_n = cnt_q;
        if (tgt != tgt_q) begin
            // retarget / request
            tgt_n = tgt;
            cnt_n = '0;
            if (tgt == SRC_PRI && !stb_q) begin
                st_n = ST_STARTUP;
            end else if (tgt == cur_q) begin
                st_n = ST_RUN;
                en_n = 1'b1;
            end else begin
                st_n = ST_HANDOFF;
                en_n = 1'b0;
            end
        end else begin
            unique case (st_q)
                ST_RUN: ;
                ST_STARTUP: begin
                    if (pri_tick) begin
                        if (cnt_q == CW'(OST_TICKS - 1)) begin
                            cnt_n = '0;
                            if (USE_PLL) begin
                                st_n = ST_LOCK;
                            end else begin
                                st_n = ST_HANDOFF;
                                en_n = 1'b0;
                            end
                        end else begin
                            cnt_n = cnt_q + 1'b1;
                        end
                    end
                end
                ST_LOCK: begin
                    if (cnt_q == CW'(LOCK_CYC - 1)) begin
                        cnt_n = '0;
                        st_n  = ST_HANDOFF;
                        en_n  = 1'b0;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
                ST_HANDOFF: begin
                    if (dest_tick) begin
                        if (cnt_q == CW'(1)) begin
                            cnt_n = '0;
                            st_n  = ST_RUN;
                            cur_n = tgt_q;
                            en_n  = 1'b1;
                            stb_n = (tgt_q == SRC_PRI);
                        end else begin
                            cnt_n = cnt_q + 1'b1;
                        end
                    end
                end
                default: st_n = ST_RUN;
            endcase
        end
    end

    // Outputs
    always_comb begin
        cur        = cur_q;
        out_en     = en_q;
        pri_stable = stb_q;
        pri_on     = (cur_q == SRC_PRI) || (tgt_q == SRC_PRI);
    end
endmodule

// File: rtl/clksw_top.sv
module clksw_top
    import clksw_pkg::*;
#(
    parameter int PRI_DIV   = 2,
    parameter int SEC_DIV   = 16,
    parameter int INT_DIV   = 4,
    parameter int PSW       = 2,
    parameter int OST_TICKS = 1024,
    parameter int LOCK_CYC  = 64,
    parameter bit USE_PLL   = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     sel_in,
    input  logic [PSW-1:0] int_div_sel,
    output logic           sys_tick,
    output logic [1:0]     active_src,
    output logic           pri_stable,
    output logic           pri_on
);
    localparam int MAXC = (OST_TICKS > LOCK_CYC) ? OST_TICKS : LOCK_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [1:0] sel_s1, sel_s2;
    logic [2:0] raw_tick;
    logic [2:0] src_tick;
    logic       int_tick;
    logic       out_en;
    src_e       cur;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_s1 <= 2'b00;
            sel_s2 <= 2'b00;
        end else begin
            sel_s1 <= sel_in;
            sel_s2 <= sel_s1;
        end
    end

    for (genvar g = 0; g < 3; g++) begin : g_osc
        localparam int D = (g == 0) ? PRI_DIV : ((g == 1) ? SEC_DIV : INT_DIV);
        clksw_divider #(.DIV(D)) u_div (
            .clk  (clk),
            .rst_n(rst_n),
            .en   ((g == 0) ? pri_on : 1'b1),
            .tick (raw_tick[g])
        );
    end

    clksw_postscale #(.PSW(PSW)) u_post (
        .clk      (clk),
        .rst_n    (rst_n),
        .base_tick(raw_tick[2]),
        .exp_sel  (int_div_sel),
        .tick     (int_tick)
    );

    always_comb src_tick = {int_tick, raw_tick[1], raw_tick[0]};

    clksw_fsm #(
        .OST_TICKS(OST_TICKS),
        .LOCK_CYC (LOCK_CYC),
        .USE_PLL  (USE_PLL),
        .CW       (CW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tgt       (decode_sel(sel_s2)),
        .src_tick  (src_tick),
        .cur       (cur),
        .out_en    (out_en),
        .pri_stable(pri_stable),
        .pri_on    (pri_on)
    );

    always_comb begin
        sys_tick   = out_en & src_tick[cur];
        active_src = cur;
    end
endmodule

// File: rtl/clksw_chk.sv
module clksw_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sys_tick,
    input logic [1:0] active_src,
    input logic       pri_stable,
    input logic       pri_on
);
    a_r1_legal_src: assert property (@(posedge clk) disable iff (!rst_n)
        active_src != 2'b11);

    a_r6_stable_only_primary: assert property (@(posedge clk) disable iff (!rst_n)
        (active_src != 2'b00) |-> !pri_stable);

    a_r6_stable_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
        pri_stable |-> pri_on);

    a_r5_quiet_before_swap: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_src) |-> !$past(sys_tick));

    a_r5_no_runt: assert property (@(posedge clk) disable iff (!rst_n)
        sys_tick |=> !sys_tick);

    a_r6_rise_on_primary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pri_stable) |-> (active_src == 2'b00));
endmodule

bind clksw_top clksw_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sys_tick  (sys_tick),
    .active_src(active_src),
    .pri_stable(pri_stable),
    .pri_on    (pri_on)
);

// File: tb/sim_clksw_top.sv
module sim_clksw_top;
    localparam int CLK_PERIOD = 10;
    localparam int T_START    = 1024 * 2 + 64;
    localparam int NV         = 7;
    localparam int V_SEL [NV] = '{1, 2, 3, 1, 3, 0, 0};
    localparam int V_SRC [NV] = '{1, 2, 2, 1, 2, 0, 0};
    localparam int V_PER [NV] = '{16, 4, 4, 16, 4, 2, 2};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel_in = 2'b00;
    logic [1:0] int_div_sel = 2'b00;
    logic       sys_tick;
    logic [1:0] active_src;
    logic       pri_stable;
    logic       pri_on;

    int nchk = 0, nfail = 0;
    int cyc = 0, last_t = 0, last_iv = 0, min_iv = 1 << 30, max_iv = 0, ntick = 0;
    bit have_last = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    clksw_top u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_in     (sel_in),
        .int_div_sel(int_div_sel),
        .sys_tick   (sys_tick),
        .active_src (active_src),
        .pri_stable (pri_stable),
        .pri_on     (pri_on)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n && sys_tick) begin
            if (have_last) begin
                last_iv = cyc - last_t;
                if (last_iv < min_iv) min_iv = last_iv;
                if (last_iv > max_iv) max_iv = last_iv;
            end
            last_t    = cyc;
            have_last = 1;
            ntick     = ntick + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic window_reset();
        min_iv = 1 << 30;
        max_iv = 0;
    endtask

    task automatic wait_src(input int exp, output int elapsed);
        int t0 = cyc;
        while (int'(active_src) != exp && cyc - t0 < 8000) step(1);
        elapsed = cyc - t0;
    endtask

    task automatic wait_ticks(input int n);
        int n0 = ntick;
        int t0 = cyc;
        while (ntick < n0 + n && cyc - t0 < 4000) step(1);
    endtask

    initial begin
        step(CLK_PERIOD * 15000);
        nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        int el, prev, t0;
        step(5);
        rst_n = 1'b1;
        step(2);
        // R2 reset state
        chk(active_src == 2'b00, "R2", "active_src after reset", active_src, 0);
        chk(pri_stable == 1'b0, "R2", "pri_stable after reset", pri_stable, 0);
        chk(pri_on == 1'b1, "R2", "pri_on after reset", pri_on, 1);
        t0 = cyc;
        while (ntick == 0 && cyc - t0 < 6000) step(1);
        chk(cyc - t0 >= T_START - 4, "R2", "first tick not before start-up+lock", cyc - t0, T_START);
        chk(cyc - t0 <= T_START + 40, "R3", "first tick after start-up+lock", cyc - t0, T_START);
        step(2);
        chk(pri_stable == 1'b1, "R6", "pri_stable after first handoff", pri_stable, 1);
        wait_ticks(3);
        chk(last_iv == 2, "R10", "primary period", last_iv, 2);
        prev = 2;

        // Table of select writes
        for (int k = 0; k < NV; k++) begin
            window_reset();
            sel_in = 2'(V_SEL[k]);
            step(4);
            wait_src(V_SRC[k], el);
            wait_ticks(3);
            chk(int'(active_src) == V_SRC[k], "R1", "active_src decode", active_src, V_SRC[k]);
            chk(last_iv == V_PER[k], "R10", "period on new source", last_iv, V_PER[k]);
            chk(pri_stable == (V_SRC[k] == 0), "R6", "pri_stable level", pri_stable, V_SRC[k] == 0);
            chk(pri_on == (V_SRC[k] == 0), "R6", "pri_on level", pri_on, V_SRC[k] == 0);
            chk(min_iv >= ((prev < V_PER[k]) ? prev : V_PER[k]), "R5", "shortest tick spacing",
                min_iv, (prev < V_PER[k]) ? prev : V_PER[k]);
            if (prev == V_PER[k])
                chk(max_iv == prev, "R1", "no gap when source unchanged", max_iv, prev);
            else
                chk(max_iv <= prev + 4 * V_PER[k] + 8, "R8", "handoff gap bounded",
                    max_iv, prev + 4 * V_PER[k] + 8);
            if (V_SRC[k] == 0 && prev != 2)
                chk(el >= T_START, "R3", "primary start-up wait", el, T_START);
            prev = V_PER[k];
        end

        // R4: old clock keeps running during start-up
        sel_in = 2'b10;
        wait_src(2, el);
        wait_ticks(2);
        window_reset();
        sel_in = 2'b00;
        step(2000);
        chk(active_src == 2'b10, "R4", "source held during wait", active_src, 2);
        chk(max_iv == 4 && min_iv == 4, "R4", "old period kept during wait", max_iv, 4);
        chk(pri_on == 1'b1, "R3", "primary powered during wait", pri_on, 1);
        wait_src(0, el);
        wait_ticks(3);
        chk(pri_stable == 1'b1, "R6", "stable after return", pri_stable, 1);

        // R9: drop a pending handoff by writing the running source back
        sel_in = 2'b10;
        step(5);
        sel_in = 2'b00;
        step(60);
        chk(active_src == 2'b00, "R9", "aborted switch keeps primary", active_src, 0);
        chk(pri_stable == 1'b1, "R9", "stable kept after abort", pri_stable, 1);
        wait_ticks(3);
        chk(last_iv == 2, "R9", "primary period after abort", last_iv, 2);

        // R9: retarget during primary start-up
        sel_in = 2'b11;
        wait_src(2, el);
        sel_in = 2'b00;
        step(500);
        sel_in = 2'b01;
        t0 = cyc;
        wait_src(1, el);
        chk(el < 200, "R9", "newest target reached without start-up", el, 200);
        step(2);
        chk(pri_on == 1'b0, "R9", "primary powered down", pri_on, 0);

        // R7: postscaler select takes effect at once
        sel_in = 2'b10;
        wait_src(2, el);
        wait_ticks(2);
        window_reset();
        int_div_sel = 2'd2;
        wait_ticks(3);
        chk(last_iv == 16, "R7", "internal period with select 2", last_iv, 16);
        int_div_sel = 2'd1;
        wait_ticks(3);
        chk(last_iv == 8, "R7", "internal period with select 1", last_iv, 8);
        chk(active_src == 2'b10, "R7", "no handoff on postscaler write", active_src, 2);
        chk(min_iv >= 4, "R7", "no runt on postscaler write", min_iv, 4);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule